// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns one 32-bit instruction word into the full set of control signals that a small single-cycle 64-bit core needs for its datapath. It is purely combinational: the controls depend only on the instruction bits that are present in the same cycle. No register, ALU, memory or program-counter logic is inside it.

The decoder recognises a fixed subset of instructions:

- loads and stores of a doubleword with an unsigned scaled immediate offset;
- add, subtract, bitwise-and and bitwise-or, each in immediate and shifted-register forms;
- the flag-setting add, subtract and and;
- the conditional branch.

Alongside the datapath controls it reports the branch condition field, a strobe that tells the flag register to capture the ALU flags, and a strobe that marks a conditional branch. Any other bit pattern falls to an inert default that writes neither the register file nor memory.

Top module: `insn_ctrl_decode`

## Requirements
- R1: When bits [31:22] equal 10'h3E5 (load), reg_wr_o=1, wb_from_mem_o=1, alu_src_imm_o=1, alu_op_o=00 (add), imm_kind_o=10 (scaled 12-bit offset), mem_wr_o=0, rd_b_from_rt_o=0.
- R2: When bits [31:22] equal 10'h3E4 (store), mem_wr_o=1, reg_wr_o=0, wb_from_mem_o=0, rd_b_from_rt_o=1 (second read port addressed by bits [4:0]), alu_src_imm_o=1, alu_op_o=00, imm_kind_o=10.
- R3: Top byte 8'h91, 8'hD1, 8'hB1 or 8'hF1 with bit 23 clear is an immediate add/subtract: reg_wr_o=1, alu_src_imm_o=1, imm_kind_o=00 (12-bit arithmetic immediate), alu_op_o=00 for 91/B1 and 01 (subtract) for D1/F1.
- R4: Top byte 8'h92, 8'hB2 or 8'hF2 with bit 23 clear is an immediate logical operation: reg_wr_o=1, alu_src_imm_o=1, imm_kind_o=01 (bitmask immediate), alu_op_o=10 (and) for 92/F2 and 11 (or) for B2.
- R5: Top byte 8'h8B, 8'hAB (add), 8'hCB, 8'hEB (subtract), 8'h8A, 8'hEA (and) or 8'hAA (or) with bit 21 clear is a shifted-register operation: reg_wr_o=1, alu_src_imm_o=0, imm_kind_o=00, alu_op_o as listed.
- R6: flag_set_o is 1 only for top bytes 8'hB1, 8'hF1, 8'hF2, 8'hAB, 8'hEB and 8'hEA when the form qualifier of R3, R4 or R5 holds; a flag-setting instruction still writes the register file.
- R7: Top byte 8'h54 with bit 4 clear is a conditional branch: branch_o=1, reg_wr_o=0, mem_wr_o=0, wb_from_mem_o=0, flag_set_o=0, alu_src_imm_o=0, alu_op_o=00, imm_kind_o=11 (19-bit word offset in bits [23:5]).
- R8: cond_o always equals instruction bits [3:0], whatever the instruction.
- R9: Every other encoding (including 8'h54 with bit 4 set, immediate top bytes with bit 23 set, shifted-register top bytes with bit 21 set, and 32-bit variants) drives every control output other than cond_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word being executed |
| rd_b_from_rt_o | output | 1 | Second register read address taken from bits [4:0] instead of [20:16] |
| reg_wr_o | output | 1 | Register file write enable |
| imm_kind_o | output | 2 | Immediate format selector for the extender |
| alu_src_imm_o | output | 1 | ALU second operand is the extended immediate |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 sub, 10 and, 11 or |
| mem_wr_o | output | 1 | Data memory write enable |
| wb_from_mem_o | output | 1 | Write-back value comes from data memory |
| flag_set_o | output | 1 | Flag register captures the ALU flags this cycle |
| branch_o | output | 1 | Instruction is a conditional branch |
| cond_o | output | 4 | Branch condition field |

## Verification
A flag-setting instruction must raise both the register write enable and the flag capture strobe in the same cycle, and the condition field is produced on every cycle next to whatever controls the instruction selects. The table drives each flag-setting opcode in immediate and shifted-register form and compares the whole control word at once, so a missing write enable or a stray flag strobe shows up together. A sweep over all sixteen condition values on branch words, and on non-branch words, checks that the field passes through while the branch strobe follows bit 4 alone.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

  localparam int INSN_W     = 32;
  localparam int COND_W     = 4;
  localparam int ALU_OP_W   = 2;
  localparam int IMM_KIND_W = 2;
  localparam int TOP_W      = 8;
  localparam int LDST_W     = 10;

  // Top-byte opcodes of the recognised 64-bit forms
  localparam logic [TOP_W-1:0] OPC_ADD_I   = 8'h91;
  localparam logic [TOP_W-1:0] OPC_SUB_I   = 8'hD1;
  localparam logic [TOP_W-1:0] OPC_ADDS_I  = 8'hB1;
  localparam logic [TOP_W-1:0] OPC_SUBS_I  = 8'hF1;
  localparam logic [TOP_W-1:0] OPC_AND_I   = 8'h92;
  localparam logic [TOP_W-1:0] OPC_ORR_I   = 8'hB2;
  localparam logic [TOP_W-1:0] OPC_ANDS_I  = 8'hF2;
  localparam logic [TOP_W-1:0] OPC_ADD_R   = 8'h8B;
  localparam logic [TOP_W-1:0] OPC_ADDS_R  = 8'hAB;
  localparam logic [TOP_W-1:0] OPC_SUB_R   = 8'hCB;
  localparam logic [TOP_W-1:0] OPC_SUBS_R  = 8'hEB;
  localparam logic [TOP_W-1:0] OPC_AND_R   = 8'h8A;
  localparam logic [TOP_W-1:0] OPC_ANDS_R  = 8'hEA;
  localparam logic [TOP_W-1:0] OPC_ORR_R   = 8'hAA;
  localparam logic [TOP_W-1:0] OPC_BCOND   = 8'h54;
  localparam logic [TOP_W-1:0] OPC_LDST_HI = 8'hF9;
  localparam logic [LDST_W-1:0] OPC_LOAD   = 10'h3E5;
  localparam logic [LDST_W-1:0] OPC_STORE  = 10'h3E4;

  typedef enum logic [ALU_OP_W-1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_ORR = 2'b11
  } alu_op_e;

  typedef enum logic [IMM_KIND_W-1:0] {
    IMM_ARITH12 = 2'b00,
    IMM_BITMASK = 2'b01,
    IMM_LDST12  = 2'b10,
    IMM_BR19    = 2'b11
  } imm_kind_e;

  typedef enum logic [2:0] {
    CLS_NONE      = 3'd0,
    CLS_LOAD      = 3'd1,
    CLS_STORE     = 3'd2,
    CLS_ARITH_IMM = 3'd3,
    CLS_LOGIC_IMM = 3'd4,
    CLS_SHREG     = 3'd5,
    CLS_BCOND     = 3'd6
  } insn_cls_e;

  typedef struct packed {
    insn_cls_e cls;
    alu_op_e   op;
    logic      sets_flags;
  } insn_class_t;

  typedef struct packed {
    logic      rd_b_from_rt;
    logic      reg_wr;
    imm_kind_e imm_kind;
    logic      alu_src_imm;
    alu_op_e   alu_op;
    logic      mem_wr;
    logic      wb_from_mem;
    logic      flag_set;
    logic      branch;
  } ctl_word_t;

  localparam ctl_word_t CTL_IDLE = '{
    rd_b_from_rt: 1'b0, reg_wr: 1'b0, imm_kind: IMM_ARITH12,
    alu_src_imm: 1'b0, alu_op: ALU_ADD, mem_wr: 1'b0,
    wb_from_mem: 1'b0, flag_set: 1'b0, branch: 1'b0
  };

  localparam insn_class_t CLASS_NONE = '{cls: CLS_NONE, op: ALU_ADD, sets_flags: 1'b0};

  function automatic insn_class_t mk_class(insn_cls_e c, alu_op_e o, logic f);
    insn_class_t r;
    r.cls        = c;
    r.op         = o;
    r.sets_flags = f;
    return r;
  endfunction

endpackage

// File: rtl/ctl_opclass.sv
module ctl_opclass
  import ctl_dec_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output insn_class_t       class_o,
  output logic              hit_arith_imm_o,
  output logic              hit_logic_imm_o,
  output logic              hit_shreg_o,
  output logic              hit_ldst_o,
  output logic              hit_bcond_o
);

  logic [TOP_W-1:0]  top_byte;
  logic [LDST_W-1:0] ldst_key;
  logic              imm_form_ok;
  logic              shreg_form_ok;
  logic              bcond_form_ok;

  assign top_byte      = insn_i[INSN_W-1 -: TOP_W];
  assign ldst_key      = insn_i[INSN_W-1 -: LDST_W];
  assign imm_form_ok   = ~insn_i[23];
  assign shreg_form_ok = ~insn_i[21];
  assign bcond_form_ok = ~insn_i[4];

  always_comb begin
    class_o = CLASS_NONE;
    case (top_byte)
      OPC_ADD_I:   if (imm_form_ok)   class_o = mk_class(CLS_ARITH_IMM, ALU_ADD, 1'b0);
      OPC_SUB_I:   if (imm_form_ok)   class_o = mk_class(CLS_ARITH_IMM, ALU_SUB, 1'b0);
      OPC_ADDS_I:  if (imm_form_ok)   class_o = mk_class(CLS_ARITH_IMM, ALU_ADD, 1'b1);
      OPC_SUBS_I:  if (imm_form_ok)   class_o = mk_class(CLS_ARITH_IMM, ALU_SUB, 1'b1);
      OPC_AND_I:   if (imm_form_ok)   class_o = mk_class(CLS_LOGIC_IMM, ALU_AND, 1'b0);
      OPC_ORR_I:   if (imm_form_ok)   class_o = mk_class(CLS_LOGIC_IMM, ALU_ORR, 1'b0);
      OPC_ANDS_I:  if (imm_form_ok)   class_o = mk_class(CLS_LOGIC_IMM, ALU_AND, 1'b1);
      OPC_ADD_R:   if (shreg_form_ok) class_o = mk_class(CLS_SHREG, ALU_ADD, 1'b0);
      OPC_ADDS_R:  if (shreg_form_ok) class_o = mk_class(CLS_SHREG, ALU_ADD, 1'b1);
      OPC_SUB_R:   if (shreg_form_ok) class_o = mk_class(CLS_SHREG, ALU_SUB, 1'b0);
      OPC_SUBS_R:  if (shreg_form_ok) class_o = mk_class(CLS_SHREG, ALU_SUB, 1'b1);
      OPC_AND_R:   if (shreg_form_ok) class_o = mk_class(CLS_SHREG, ALU_AND, 1'b0);
      OPC_ANDS_R:  if (shreg_form_ok) class_o = mk_class(CLS_SHREG, ALU_AND, 1'b1);
      OPC_ORR_R:   if (shreg_form_ok) class_o = mk_class(CLS_SHREG, ALU_ORR, 1'b0);
      OPC_BCOND:   if (bcond_form_ok) class_o = mk_class(CLS_BCOND, ALU_ADD, 1'b0);
      OPC_LDST_HI: begin
        if (ldst_key == OPC_LOAD)       class_o = mk_class(CLS_LOAD, ALU_ADD, 1'b0);
        else if (ldst_key == OPC_STORE) class_o = mk_class(CLS_STORE, ALU_ADD, 1'b0);
      end
      default: class_o = CLASS_NONE;
    endcase
  end

  assign hit_arith_imm_o = (class_o.cls == CLS_ARITH_IMM);
  assign hit_logic_imm_o = (class_o.cls == CLS_LOGIC_IMM);
  assign hit_shreg_o     = (class_o.cls == CLS_SHREG);
  assign hit_ldst_o      = (class_o.cls == CLS_LOAD) || (class_o.cls == CLS_STORE);
  assign hit_bcond_o     = (class_o.cls == CLS_BCOND);

endmodule

// File: rtl/ctl_signal_map.sv
module ctl_signal_map
  import ctl_dec_pkg::*;
(
  input  insn_class_t class_i,
  output ctl_word_t   ctl_o
);

  always_comb begin
    ctl_o = CTL_IDLE;
    case (class_i.cls)
      CLS_LOAD: begin
        ctl_o.reg_wr      = 1'b1;
        ctl_o.imm_kind    = IMM_LDST12;
        ctl_o.alu_src_imm = 1'b1;
        ctl_o.alu_op      = ALU_ADD;
        ctl_o.wb_from_mem = 1'b1;
      end
      CLS_STORE: begin
        ctl_o.rd_b_from_rt = 1'b1;
        ctl_o.imm_kind     = IMM_LDST12;
        ctl_o.alu_src_imm  = 1'b1;
        ctl_o.alu_op       = ALU_ADD;
        ctl_o.mem_wr       = 1'b1;
      end
      CLS_ARITH_IMM: begin
        ctl_o.reg_wr      = 1'b1;
        ctl_o.imm_kind    = IMM_ARITH12;
        ctl_o.alu_src_imm = 1'b1;
        ctl_o.alu_op      = class_i.op;
        ctl_o.flag_set    = class_i.sets_flags;
      end
      CLS_LOGIC_IMM: begin
        ctl_o.reg_wr      = 1'b1;
        ctl_o.imm_kind    = IMM_BITMASK;
        ctl_o.alu_src_imm = 1'b1;
        ctl_o.alu_op      = class_i.op;
        ctl_o.flag_set    = class_i.sets_flags;
      end
      CLS_SHREG: begin
        ctl_o.reg_wr   = 1'b1;
        ctl_o.alu_op   = class_i.op;
        ctl_o.flag_set = class_i.sets_flags;
      end
      CLS_BCOND: begin
        ctl_o.imm_kind = IMM_BR19;
        ctl_o.branch   = 1'b1;
      end
      default: ctl_o = CTL_IDLE;
    endcase
  end

endmodule

// File: rtl/insn_ctrl_decode.sv
module insn_ctrl_decode
  import ctl_dec_pkg::*;
(
  input  logic [INSN_W-1:0]     insn_i,
  output logic                  rd_b_from_rt_o,
  output logic                  reg_wr_o,
  output logic [IMM_KIND_W-1:0] imm_kind_o,
  output logic                  alu_src_imm_o,
  output logic [ALU_OP_W-1:0]   alu_op_o,
  output logic                  mem_wr_o,
  output logic                  wb_from_mem_o,
  output logic                  flag_set_o,
  output logic                  branch_o,
  output logic [COND_W-1:0]     cond_o
);

  insn_class_t cls_w;
  ctl_word_t   ctl_w;
  logic        hit_arith_imm;
  logic        hit_logic_imm;
  logic        hit_shreg;
  logic        hit_ldst;
  logic        hit_bcond;

  ctl_opclass u_class (
    .insn_i          (insn_i),
    .class_o         (cls_w),
    .hit_arith_imm_o (hit_arith_imm),
    .hit_logic_imm_o (hit_logic_imm),
    .hit_shreg_o     (hit_shreg),
    .hit_ldst_o      (hit_ldst),
    .hit_bcond_o     (hit_bcond)
  );

  ctl_signal_map u_map (
    .class_i (cls_w),
    .ctl_o   (ctl_w)
  );

  assign rd_b_from_rt_o = ctl_w.rd_b_from_rt;
  assign reg_wr_o       = ctl_w.reg_wr;
  assign imm_kind_o     = ctl_w.imm_kind;
  assign alu_src_imm_o  = ctl_w.alu_src_imm;
  assign alu_op_o       = ctl_w.alu_op;
  assign mem_wr_o       = ctl_w.mem_wr;
  assign wb_from_mem_o  = ctl_w.wb_from_mem;
  assign flag_set_o     = ctl_w.flag_set;
  assign branch_o       = ctl_w.branch;
  assign cond_o         = insn_i[COND_W-1:0];

endmodule

// File: rtl/insn_ctrl_decode_chk.sv
module insn_ctrl_decode_chk
  import ctl_dec_pkg::*;
(
  input logic [INSN_W-1:0]     insn_i,
  input logic                  rd_b_from_rt_o,
  input logic                  reg_wr_o,
  input logic [IMM_KIND_W-1:0] imm_kind_o,
  input logic                  alu_src_imm_o,
  input logic [ALU_OP_W-1:0]   alu_op_o,
  input logic                  mem_wr_o,
  input logic                  wb_from_mem_o,
  input logic                  flag_set_o,
  input logic                  branch_o,
  input logic                  hit_ldst,
  input logic                  hit_bcond
);

  always_comb begin
    if (!$isunknown(insn_i)) begin
      // R1: a load writes back through the adder with the immediate
      p_load_path_r1: assert (!wb_from_mem_o ||
                              (reg_wr_o && alu_src_imm_o && alu_op_o == 2'b00 && hit_ldst))
        else $error("load path controls inconsistent");
      // R2: a store never writes the register file
      p_store_no_wb_r2: assert (!mem_wr_o || (!reg_wr_o && !wb_from_mem_o && rd_b_from_rt_o))
        else $error("store raised a write-back control");
      // R4: the bitmask immediate only feeds logical operations
      p_bitmask_logic_r4: assert (!(reg_wr_o && imm_kind_o == 2'b01) || alu_op_o[1])
        else $error("bitmask immediate with arithmetic op");
      // R6: flag capture accompanies a register write
      p_flag_writes_r6: assert (!flag_set_o || (reg_wr_o && !mem_wr_o && !wb_from_mem_o))
        else $error("flag strobe without register write");
      // R7: a branch touches no state other than the PC
      p_branch_quiet_r7: assert (!branch_o ||
                                 (hit_bcond && !reg_wr_o && !mem_wr_o && !flag_set_o &&
                                  imm_kind_o == 2'b11))
        else $error("branch raised a state write");
      // R9: at most one of the memory and branch strobes
      p_strobe_excl_r9: assert ($onehot0({mem_wr_o, wb_from_mem_o, branch_o}))
        else $error("conflicting strobes");
      // R9: an instruction doing nothing leaves every control at rest
      p_idle_zero_r9: assert (reg_wr_o || mem_wr_o || branch_o ||
                              ({rd_b_from_rt_o, imm_kind_o, alu_src_imm_o, alu_op_o,
                                wb_from_mem_o, flag_set_o} == '0))
        else $error("unrecognised word left a control set");
    end
  end

endmodule

bind insn_ctrl_decode insn_ctrl_decode_chk u_chk (
  .insn_i         (insn_i),
  .rd_b_from_rt_o (rd_b_from_rt_o),
  .reg_wr_o       (reg_wr_o),
  .imm_kind_o     (imm_kind_o),
  .alu_src_imm_o  (alu_src_imm_o),
  .alu_op_o       (alu_op_o),
  .mem_wr_o       (mem_wr_o),
  .wb_from_mem_o  (wb_from_mem_o),
  .flag_set_o     (flag_set_o),
  .branch_o       (branch_o),
  .hit_ldst       (hit_ldst),
  .hit_bcond      (hit_bcond)
);

// File: tb/insn_ctrl_decode_tb.sv
`timescale 1ns/1ps
module insn_ctrl_decode_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn;
  logic        rd_b_from_rt, reg_wr, alu_src_imm, mem_wr, wb_from_mem, flag_set, branch;
  logic [1:0]  imm_kind, alu_op;
  logic [3:0]  cond;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  insn_ctrl_decode dut_i (
    .insn_i         (insn),
    .rd_b_from_rt_o (rd_b_from_rt),
    .reg_wr_o       (reg_wr),
    .imm_kind_o     (imm_kind),
    .alu_src_imm_o  (alu_src_imm),
    .alu_op_o       (alu_op),
    .mem_wr_o       (mem_wr),
    .wb_from_mem_o  (wb_from_mem),
    .flag_set_o     (flag_set),
    .branch_o       (branch),
    .cond_o         (cond)
  );

  // Expected word: {rt_sel, reg_wr, imm_kind[1:0], alu_imm, alu_op[1:0], mem_wr, wb_mem, fset, br}
  localparam int NV = 29;
  localparam logic [42:0] VEC [NV] = '{
    {32'hF9400441, 11'b0_1_10_1_00_0_1_0_0}, // R1 load
    {32'hF9000441, 11'b1_0_10_1_00_1_0_0_0}, // R2 store
    {32'h91000421, 11'b0_1_00_1_00_0_0_0_0}, // R3 add imm
    {32'hD1000421, 11'b0_1_00_1_01_0_0_0_0}, // R3 sub imm
    {32'hB1000421, 11'b0_1_00_1_00_0_0_1_0}, // R6 adds imm
    {32'hF1000421, 11'b0_1_00_1_01_0_0_1_0}, // R6 subs imm
    {32'h92400421, 11'b0_1_01_1_10_0_0_0_0}, // R4 and imm
    {32'hB2400421, 11'b0_1_01_1_11_0_0_0_0}, // R4 orr imm
    {32'hF2400421, 11'b0_1_01_1_10_0_0_1_0}, // R6 ands imm
    {32'h8B030041, 11'b0_1_00_0_00_0_0_0_0}, // R5 add reg
    {32'hCB030041, 11'b0_1_00_0_01_0_0_0_0}, // R5 sub reg
    {32'h8A030041, 11'b0_1_00_0_10_0_0_0_0}, // R5 and reg
    {32'hAA030041, 11'b0_1_00_0_11_0_0_0_0}, // R5 orr reg
    {32'hEA030041, 11'b0_1_00_0_10_0_0_1_0}, // R6 ands reg
    {32'hAB030041, 11'b0_1_00_0_00_0_0_1_0}, // R6 adds reg
    {32'hEB030041, 11'b0_1_00_0_01_0_0_1_0}, // R6 subs reg
    {32'h54000040, 11'b0_0_11_0_00_0_0_0_1}, // R7 eq
    {32'h54000041, 11'b0_0_11_0_00_0_0_0_1}, // R7 ne
    {32'h5400004B, 11'b0_0_11_0_00_0_0_0_1}, // R7 lt
    {32'h5400004C, 11'b0_0_11_0_00_0_0_0_1}, // R7 gt
    {32'h5400004E, 11'b0_0_11_0_00_0_0_0_1}, // R7 al
    {32'h5400005B, 11'b0}, // R9 branch opcode, bit4 set
    {32'h91800421, 11'b0}, // R9 add imm, bit23 set
    {32'h92800421, 11'b0}, // R9 logical imm, bit23 set
    {32'h8B230041, 11'b0}, // R9 shifted form, bit21 set
    {32'hF9800441, 11'b0}, // R9 other load key
    {32'h11000421, 11'b0}, // R9 32-bit add
    {32'hD65F03C0, 11'b0}, // R9 return
    {32'h00000000, 11'b0}  // R9 all zero
  };

  string vtag [NV] = '{
    "R1", "R2", "R3", "R3", "R6", "R6", "R4", "R4", "R6",
    "R5", "R5", "R5", "R5", "R6", "R6", "R6",
    "R7", "R7", "R7", "R7", "R7",
    "R9", "R9", "R9", "R9", "R9", "R9", "R9", "R9"
  };

  function automatic logic [10:0] out_word();
    return {rd_b_from_rt, reg_wr, imm_kind, alu_src_imm, alu_op,
            mem_wr, wb_from_mem, flag_set, branch};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp, logic [31:0] w);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s insn=%08h got=%0h expected=%0h", tag, w, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    insn = w;
    #1;
  endtask

  initial begin
    insn = 32'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state with an all-zero word (R9)
    apply(32'h0);
    check("R9", {21'b0, out_word()}, 32'h0, insn);

    // Table walk; the condition field is checked on every row (R8)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][42:11]);
      check(vtag[i], {21'b0, out_word()}, {21'b0, VEC[i][10:0]}, insn);
      check("R8", {28'b0, cond}, {28'b0, VEC[i][14:11]}, insn);
    end

    // All sixteen conditions on branch words: strobe follows bit 4 (R7, R8, R9)
    for (int c = 0; c < 16; c++) begin
      apply(32'h54FFFFE0 | c);
      check("R7", {30'b0, branch, reg_wr}, 32'h2, insn);
      check("R8", {28'b0, cond}, c, insn);
      apply(32'h54FFFFF0 | c);
      check("R9", {21'b0, out_word()}, 32'h0, insn);
      check("R8", {28'b0, cond}, c, insn);
    end

    // Store with every register field set still reads Rt and never writes back (R2)
    apply(32'hF93FFFFF);
    check("R2", {21'b0, out_word()}, {21'b0, 11'b1_0_10_1_00_1_0_0_0}, insn);

    // Load then flag-setting subtract back to back: no strobe carries over (R1, R6)
    apply(32'hF97FFFFF);
    check("R1", {21'b0, out_word()}, {21'b0, 11'b0_1_10_1_00_0_1_0_0}, insn);
    apply(32'hEBDFFFFF);
    check("R6", {21'b0, out_word()}, {21'b0, 11'b0_1_00_0_01_0_0_1_0}, insn);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule